// File: doc/BRIEF.md
# Handshaked Two-Tap Averaging Filter

This block is a streaming filter that sits between two four-phase request/acknowledge channels. For every sample taken from the input channel, it presents the mean of that sample and the sample before it on the output channel. It then remembers the new sample as the history for the next one. The history starts at zero, so the first result after reset is half the first sample.

A small control state machine orders the work. It captures the input word and acknowledges it. It then starts a one-cycle adder and waits for the adder's done strobe. Next it places the halved sum in an output register and raises the output request. Once the receiver acknowledges, it drops the request, updates the history, and finally returns the input acknowledge to zero after the sender withdraws its request. Both channels follow the full return-to-zero sequence, and a new sample is taken only when both channels are idle.

Top module: `avg2_filter`

## Requirements
- R1: After reset, in_ack and out_req are 0, out_data is 0 and the stored history is 0, so the first result equals the first sample shifted right by one.
- R2: Each result is bits [W:1] of the (W+1)-bit sum of the captured sample and the history, which is the mean truncated toward zero.
- R3: The history takes the value of the captured sample only on the clock edge where out_req and out_ack are both high, so the next result averages with that sample.
- R4: The sample is captured on the same edge that raises in_ack; a change on in_data while in_ack is high has no effect on the result.
- R5: in_ack rises only while in_req is high, stays high as long as in_req stays high (including after the output handshake has finished), and falls on the first edge that sees in_req low once the output has been acknowledged.
- R6: While out_req is high and out_ack is low, out_req stays high and out_data stays stable; out_req falls on the first edge that sees out_ack high.
- R7: A request on in_req is not accepted while out_ack is still high: in_ack stays 0 until out_ack returns low.
- R8: The adder's done strobe is high exactly one cycle after its start strobe, and out_req rises on the edge after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | W | Input sample, valid while in_req is high |
| in_req | input | 1 | Input request |
| in_ack | output | 1 | Input acknowledge |
| out_data | output | W | Averaged result, held while out_req is high |
| out_req | output | 1 | Output request |
| out_ack | input | 1 | Output acknowledge |

## Verification
The bench builds the block with the default W = 8. At this width it can drive the extremes: two 255 samples need the ninth sum bit, and an odd sum such as 0 + 1 shows the truncation. With this width, a fixed sequence of samples makes every history value predictable. The bench can therefore check each result against a running model, including after a second reset. It also pushes both handshakes into their slow corners: it delays out_ack, holds in_req high after the output finishes, and keeps out_ack high at idle.

// File: rtl/avg2_pkg.sv
package avg2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUM  = 2'd1,
    ST_SHOW = 2'd2,
    ST_RTZ  = 2'd3
  } avg_state_e;
endpackage

// File: rtl/avg2_adder.sv
module avg2_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      done <= 1'b0;
    end else begin
      done <= go;
      if (go) sum <= {1'b0, a} + {1'b0, b};
    end
  end

  // R8: done follows start by exactly one cycle
  assert_done_after_go_R8: assert property (@(posedge clk) disable iff (rst)
    go |=> done);
  assert_done_only_after_go_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(go));
endmodule

// File: rtl/avg2_ctrl.sv
module avg2_ctrl
  import avg2_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_req,
  input  logic out_ack,
  input  logic sum_done,
  output logic in_ack,
  output logic out_req,
  output logic add_go,
  output logic cap_en,
  output logic show_en,
  output logic hist_en
);
  avg_state_e state;

  assign cap_en  = (state == ST_IDLE) && in_req && !out_ack;
  assign show_en = (state == ST_SUM) && sum_done;
  assign hist_en = (state == ST_SHOW) && out_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      in_ack  <= 1'b0;
      out_req <= 1'b0;
      add_go  <= 1'b0;
    end else begin
      add_go <= cap_en;
      case (state)
        ST_IDLE: if (cap_en) begin
          in_ack <= 1'b1;
          state  <= ST_SUM;
        end
        ST_SUM: if (show_en) begin
          out_req <= 1'b1;
          state   <= ST_SHOW;
        end
        ST_SHOW: if (hist_en) begin
          out_req <= 1'b0;
          state   <= ST_RTZ;
        end
        default: if (!in_req) begin
          in_ack <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R5: acknowledge rises only against a live request
  assert_ack_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(in_req));
  // R5: acknowledge falls only after the request has gone
  assert_ack_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> !$past(in_req));
  // R6: output request held until acknowledged
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_ack) |=> out_req);
  // R7: no capture while the output acknowledge is still high
  assert_no_accept_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> !$past(out_ack));
  // R4: output is only requested for a captured sample
  assert_req_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    out_req |-> in_ack);
endmodule

// File: rtl/avg2_filter.sv
module avg2_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_req,
  output logic         in_ack,
  output logic [W-1:0] out_data,
  output logic         out_req,
  input  logic         out_ack
);
  localparam int SW = W + 1;

  logic [W-1:0]  x_q, y_q, res_q;
  logic [SW-1:0] sum;
  logic          add_go, sum_done, cap_en, show_en, hist_en;

  avg2_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_req(in_req), .out_ack(out_ack),
    .sum_done(sum_done), .in_ack(in_ack), .out_req(out_req),
    .add_go(add_go), .cap_en(cap_en), .show_en(show_en), .hist_en(hist_en)
  );

  avg2_adder #(.W(W)) u_add (
    .clk(clk), .rst(rst), .go(add_go), .a(x_q), .b(y_q),
    .sum(sum), .done(sum_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      y_q   <= '0;
      res_q <= '0;
    end else begin
      if (cap_en)  x_q   <= in_data;
      if (show_en) res_q <= sum[SW-1:1];
      if (hist_en) y_q   <= x_q;
    end
  end

  assign out_data = res_q;

  // R3: history moves only on the output handshake
  assert_hist_on_handshake_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(y_q) |-> $past(out_req && out_ack));
  // R6: result stable while the request waits
  assert_out_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_ack) |=> $stable(out_data));
  // R4: captured sample cannot change while acknowledged
  assert_x_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(in_ack) && in_ack) |-> $stable(x_q));
  // R8: output request follows the adder's done strobe
  assert_req_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_req) |-> $past(sum_done));
endmodule

// File: tb/avg2_filter_tb_top.sv
module avg2_filter_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] in_data;
  logic         in_req, out_ack;
  logic         in_ack, out_req;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int hist   = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  avg2_filter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_req(in_req), .in_ack(in_ack),
    .out_data(out_data), .out_req(out_req), .out_ack(out_ack)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_req = 1'b0; out_ack = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    hist = 0;
    @(negedge clk);
  endtask

  // full sample exchange; ack_delay = cycles the receiver waits
  task automatic send(input int x, input int ack_delay, input bit hold_req);
    int exp, n, lat;
    exp = (x + hist) >> 1;
    in_data = W'(x); in_req = 1'b1;
    n = 0;
    while (!in_ack && n < 20) begin @(negedge clk); n++; end
    check("R4 in_ack rises", in_ack, 1);
    in_data = ~W'(x);                     // R4: change after ack has no effect
    lat = 0;
    while (!out_req && lat < 20) begin @(negedge clk); lat++; end
    check("R8 out_req latency", lat, 2);
    check("R2 result", out_data, exp);
    for (int i = 0; i < ack_delay; i++) begin
      @(negedge clk);
      check("R6 out_req held", out_req, 1);
      check("R6 out_data stable", out_data, exp);
    end
    out_ack = 1'b1;
    @(negedge clk);
    check("R6 out_req falls", out_req, 0);
    check("R5 in_ack held while in_req high", in_ack, 1);
    out_ack = 1'b0;
    if (hold_req) begin
      repeat (4) @(negedge clk);
      check("R5 in_ack still high", in_ack, 1);
      check("R5 no second capture", out_req, 0);
    end
    in_req = 1'b0;
    @(negedge clk);
    check("R5 in_ack falls", in_ack, 0);
    hist = x;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 in_ack", in_ack, 0);
    check("R1 out_req", out_req, 0);
    check("R1 out_data", out_data, 0);
  endtask

  task automatic t_stream();
    send(100, 0, 0);   // R1 first result = 50
    send(200, 1, 0);   // R3 history 100 -> 150
    send(255, 0, 0);
    send(255, 2, 0);   // R2 carry bit kept: 255
    send(0, 0, 0);     // 127
    send(1, 0, 0);     // R2 truncation: 0
  endtask

  task automatic t_slow_sides();
    send(37, 5, 1);
    send(90, 3, 1);
  endtask

  task automatic t_busy_out();
    @(negedge clk);
    out_ack = 1'b1;
    in_data = 8'd60; in_req = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 no accept while out_ack high", in_ack, 0);
    out_ack = 1'b0;
    in_req = 1'b0;
    @(negedge clk);
    send(60, 0, 0);
  endtask

  task automatic t_rereset();
    send(10, 0, 0);
    do_reset();
    send(8, 0, 0);     // R1 history cleared: 4
    send(2, 0, 0);     // R3: 5
  endtask

  initial begin
    rst = 1'b1; in_req = 1'b0; out_ack = 1'b0; in_data = '0;
    t_reset();
    t_stream();
    t_slow_sides();
    t_busy_out();
    t_rereset();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule